// File: doc/BRIEF.md
# Configurable SPI Framing Master

This block is the master side of a four-wire synchronous serial link. It makes the serial clock from the system clock through a programmable divider and drives a slave-select line. Each word moves out on MOSI while the answer is taken in from MISO, most significant bit first. Software-style configuration inputs pick the clock phase and polarity, the frame length, the select polarity and direction, and an open-drain style of driving. They also pick the master enable and a two-bit protocol field.

A word is handed over on `txData` with a one-cycle `txLoad` strobe and lands in a one-word holding register. In the standard protocol every word gets its own select window, with half an SCK period of setup before the first clock edge and half a period of hold after the last one. In the framed protocol a word that is already waiting when a frame ends follows at once. The clock keeps its cadence and select stays active until no word is waiting. Each received word appears right-justified on `rxData`, with a one-cycle `rxDone` pulse.

Configuration inputs are expected to change only while no frame is in progress.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, `sck` equals `cfgPolarity`, select is inactive, `mosi` is 0, `rxData` is 0 and `rxDone` is 0.
- R2: While `cfgEnable` is 0, `sckOe`, `mosiOe` and `sselOe` are 0 and no frame starts. Dropping `cfgEnable` during a frame abandons it on the next clock: select becomes inactive and `sck` returns to idle. A word loaded while disabled is sent once the block is enabled.
- R3: The SCK half period is `cfgHalf` system clocks, with 0 treated as 1. SCK idles at `cfgPolarity`, and a frame of N bits has exactly 2N SCK transitions.
- R4: Bits go out and come in most significant bit first. With `cfgPhase`=0, MOSI holds a bit from select assertion onward, MISO is captured on odd-numbered SCK transitions, and MOSI moves to the next bit on even ones. With `cfgPhase`=1, MOSI is 0 before the first transition of a frame that starts from idle, moves to the next bit on odd transitions, and MISO is captured on even ones. MISO is captured at the system clock edge that moves SCK.
- R5: The frame length N is `cfgBits`, with 0 meaning 8. The transmitted bits are `txData[N-1:0]`. `rxData` holds the N received bits right-justified with zeros above them, and it updates together with a one-cycle `rxDone` pulse at the clock edge of the last SCK transition.
- R6: Select is low when active and high when inactive. `cfgSelInvert`=1 reverses both levels. `sselOe` is 1 only when `cfgSelOutput` is 1.
- R7: With `cfgMode` 00, 01 or 10, select becomes active on the clock after a word is taken. The first SCK transition follows one half period later. Select goes inactive one half period after the last transition, and each word gets its own select window.
- R8: With `cfgMode`=11, if a word is waiting at the last transition of a frame, the next frame begins there. Select stays active, and the next frame's first transition comes one half period later.
- R9: With `cfgOpenDrain`=1, each of `sck`, `mosi` and `ssel` has its output enable set only while its value is 0.
- R10: `txLoad` captures `txData` into a single holding word, and a later load replaces a word that has not yet started. If the holding word is full while the block is idle and enabled, a frame starts at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| cfgEnable | input | 1 | Master enable |
| cfgMode | input | 2 | Protocol select, 11 = framed, others = standard |
| cfgPhase | input | 1 | Clock phase |
| cfgPolarity | input | 1 | SCK idle level |
| cfgSelInvert | input | 1 | Inverts the select levels |
| cfgSelOutput | input | 1 | Select pin acts as an output |
| cfgOpenDrain | input | 1 | Drive outputs low only |
| cfgBits | input | BITS_W (3) | Frame length, 0 = MAX_BITS |
| cfgHalf | input | HALF_W (4) | SCK half period in system clocks |
| txData | input | MAX_BITS (8) | Word to send |
| txLoad | input | 1 | Capture strobe for `txData` |
| miso | input | 1 | Serial data in |
| rxData | output | MAX_BITS (8) | Last received word, right-justified |
| rxDone | output | 1 | One-cycle pulse when `rxData` updates |
| sck | output | 1 | Serial clock |
| sckOe | output | 1 | Output enable for `sck` |
| mosi | output | 1 | Serial data out |
| mosiOe | output | 1 | Output enable for `mosi` |
| ssel | output | 1 | Slave select |
| sselOe | output | 1 | Output enable for `ssel` |

## Verification
All outputs except the output enables come from registers, so every effect of a clock edge shows one clock later. Select goes active on the clock after the holding word fills. SCK moves every half period after that. `rxData` and `rxDone` change at the same edge as the last SCK transition. The output enables follow the configuration inputs at once. The bench keeps a behavioural model that counts clocks since select assertion and derives the edge number, the expected SCK level, the MOSI bit and the captured MISO bits from it. Both the model and the design advance on the rising edge, and the bench compares every output 1 ns after each rising edge, while inputs change only on falling edges.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TRAIL = 2'd2
  } ctrl_state_t;

  // strobes from control to datapath, all valid for one clock
  typedef struct packed {
    logic startFrame;  // take the holding word as the next frame
    logic driveBit;    // present the next bit on MOSI
    logic sampleBit;   // capture MISO
    logic lastEdge;    // final SCK transition of the frame
    logic goIdle;      // frame abandoned or finished
  } spim_strobe_t;

  localparam logic [1:0] MODE_FRAMED = 2'b11;

endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int HALF_W   = 4,
  localparam int BITS_W  = $clog2(MAX_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgMode,
  input  logic              cfgPhase,
  input  logic [BITS_W-1:0] cfgBits,
  input  logic [HALF_W-1:0] cfgHalf,
  input  logic              pendValid,
  output spim_strobe_t      strb,
  output logic              sckRaw,
  output logic              selActive
);

  localparam int EDGE_W = $clog2(2 * MAX_BITS + 1);

  ctrl_state_t       state;
  logic [HALF_W-1:0] halfCnt;
  logic [EDGE_W-1:0] edgeCnt;

  logic [HALF_W-1:0] halfLen;
  logic [EDGE_W-1:0] frameBits;
  logic [EDGE_W-1:0] lastEdgeNum;
  logic [EDGE_W-1:0] nextEdge;
  logic              tick;
  logic              edgeNow;
  logic              isLast;
  logic              chain;

  always_comb begin
    halfLen     = (cfgHalf == '0) ? HALF_W'(1) : cfgHalf;
    frameBits   = (cfgBits == '0) ? EDGE_W'(MAX_BITS) : EDGE_W'(cfgBits);
    lastEdgeNum = frameBits << 1;
    tick        = (halfCnt == '0);
    nextEdge    = edgeCnt + 1'b1;
    edgeNow     = cfgEnable && (state == ST_SHIFT) && tick;
    isLast      = edgeNow && (nextEdge == lastEdgeNum);
    chain       = isLast && (cfgMode == MODE_FRAMED) && pendValid;

    strb            = '0;
    strb.startFrame = (cfgEnable && state == ST_IDLE && pendValid) || chain;
    strb.sampleBit  = edgeNow && (nextEdge[0] ^ cfgPhase);
    strb.driveBit   = edgeNow && !isLast && (nextEdge[0] == cfgPhase);
    strb.lastEdge   = isLast;
    strb.goIdle     = !cfgEnable || (state == ST_TRAIL && tick);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      edgeCnt <= '0;
      sckRaw  <= 1'b0;
    end else if (!cfgEnable) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      edgeCnt <= '0;
      sckRaw  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pendValid) begin
            state   <= ST_SHIFT;
            halfCnt <= halfLen - 1'b1;
            edgeCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sckRaw  <= ~sckRaw;
            halfCnt <= halfLen - 1'b1;
            if (isLast) begin
              edgeCnt <= '0;
              if (!chain) state <= ST_TRAIL;
            end else begin
              edgeCnt <= nextEdge;
            end
          end else begin
            halfCnt <= halfCnt - 1'b1;
          end
        end
        ST_TRAIL: begin
          if (tick) state <= ST_IDLE;
          else      halfCnt <= halfCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign selActive = (state != ST_IDLE);

  // R3: SCK only moves while shifting
  a_r3_sck_moves_in_shift: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && $past(cfgEnable) && sckRaw != $past(sckRaw)) |-> $past(state) == ST_SHIFT);

  // R3: no frame active means SCK at idle level
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sckRaw);

  // R7: select rises with SCK still idle and no edge counted
  a_r7_lead_half: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selActive) |-> (!sckRaw && edgeCnt == '0));

  // R8: chained frame keeps select active and stays shifting
  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lastEdge && strb.startFrame) |=> (state == ST_SHIFT && selActive));

  // R2: disabling returns to idle on the next clock
  a_r2_disable_idles: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> state == ST_IDLE);

endmodule

// File: rtl/spim_dpath.sv
module spim_dpath
  import spim_pkg::*;
#(
  parameter int MAX_BITS = 8,
  localparam int BITS_W  = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BITS_W-1:0]   cfgBits,
  input  logic                cfgPhase,
  input  spim_strobe_t        strb,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                txLoad,
  input  logic                miso,
  output logic                pendValid,
  output logic                mosiBit,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxDone
);

  logic [MAX_BITS-1:0] pendData;
  logic [MAX_BITS-1:0] shiftReg;
  logic [MAX_BITS-1:0] rxShift;
  logic [BITS_W:0]     frameLen;
  logic [BITS_W:0]     padBits;
  logic [MAX_BITS-1:0] aligned;
  logic [MAX_BITS-1:0] sampled;

  always_comb begin
    frameLen = (cfgBits == '0) ? (BITS_W + 1)'(MAX_BITS) : {1'b0, cfgBits};
    padBits  = (BITS_W + 1)'(MAX_BITS) - frameLen;
    aligned  = pendData << padBits;
    sampled  = {rxShift[MAX_BITS-2:0], miso};
  end

  // holding word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendData  <= '0;
    end else if (txLoad) begin
      pendValid <= 1'b1;
      pendData  <= txData;
    end else if (strb.startFrame) begin
      pendValid <= 1'b0;
    end
  end

  // transmit side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      mosiBit  <= 1'b0;
    end else if (strb.goIdle) begin
      mosiBit  <= 1'b0;
    end else if (strb.startFrame) begin
      shiftReg <= cfgPhase ? aligned : (aligned << 1);
      if (!cfgPhase) mosiBit <= aligned[MAX_BITS-1];
    end else if (strb.driveBit) begin
      mosiBit  <= shiftReg[MAX_BITS-1];
      shiftReg <= shiftReg << 1;
    end
  end

  // receive side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxDone  <= 1'b0;
    end else begin
      rxDone <= strb.lastEdge;
      if (strb.lastEdge) rxData <= cfgPhase ? sampled : rxShift;
      if (strb.startFrame)     rxShift <= '0;
      else if (strb.sampleBit) rxShift <= sampled;
    end
  end

  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  // R10: a started word empties the holding register unless reloaded
  a_r10_pending_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startFrame && !txLoad) |=> !pendValid);

  // R10: load captures the presented word
  a_r10_capture: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> (pendValid && pendData == $past(txData)));

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spim_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int HALF_W   = 4,
  localparam int BITS_W  = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgEnable,
  input  logic [1:0]          cfgMode,
  input  logic                cfgPhase,
  input  logic                cfgPolarity,
  input  logic                cfgSelInvert,
  input  logic                cfgSelOutput,
  input  logic                cfgOpenDrain,
  input  logic [BITS_W-1:0]   cfgBits,
  input  logic [HALF_W-1:0]   cfgHalf,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                txLoad,
  input  logic                miso,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxDone,
  output logic                sck,
  output logic                sckOe,
  output logic                mosi,
  output logic                mosiOe,
  output logic                ssel,
  output logic                sselOe
);

  spim_strobe_t strb;
  logic         pendValid;
  logic         sckRaw;
  logic         selActive;
  logic         mosiBit;

  spim_ctrl #(.MAX_BITS(MAX_BITS), .HALF_W(HALF_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgEnable (cfgEnable),
    .cfgMode   (cfgMode),
    .cfgPhase  (cfgPhase),
    .cfgBits   (cfgBits),
    .cfgHalf   (cfgHalf),
    .pendValid (pendValid),
    .strb      (strb),
    .sckRaw    (sckRaw),
    .selActive (selActive)
  );

  spim_dpath #(.MAX_BITS(MAX_BITS)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .cfgBits   (cfgBits),
    .cfgPhase  (cfgPhase),
    .strb      (strb),
    .txData    (txData),
    .txLoad    (txLoad),
    .miso      (miso),
    .pendValid (pendValid),
    .mosiBit   (mosiBit),
    .rxData    (rxData),
    .rxDone    (rxDone)
  );

  always_comb begin
    sck    = sckRaw ^ cfgPolarity;
    mosi   = mosiBit;
    ssel   = ~(selActive ^ cfgSelInvert);
    sckOe  = cfgEnable & (~cfgOpenDrain | ~sck);
    mosiOe = cfgEnable & (~cfgOpenDrain | ~mosi);
    sselOe = cfgEnable & cfgSelOutput & (~cfgOpenDrain | ~ssel);
  end

endmodule

// File: tb/tb_spi_frame_master.sv
`timescale 1ns/1ps
module tb_spi_frame_master;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgEnable, cfgPhase, cfgPolarity, cfgSelInvert, cfgSelOutput, cfgOpenDrain;
  logic [1:0] cfgMode;
  logic [2:0] cfgBits;
  logic [3:0] cfgHalf;
  logic [7:0] txData;
  logic       txLoad;
  logic       miso;
  logic [7:0] rxData;
  logic       rxDone, sck, sckOe, mosi, mosiOe, ssel, sselOe;

  logic [15:0] lfsr = 16'hACE1;
  int    nChecks = 0;
  int    nErr    = 0;
  string scen    = "reset";

  always #2 clk = ~clk;  // 250 MHz

  spi_frame_master dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMode(cfgMode),
    .cfgPhase(cfgPhase), .cfgPolarity(cfgPolarity), .cfgSelInvert(cfgSelInvert),
    .cfgSelOutput(cfgSelOutput), .cfgOpenDrain(cfgOpenDrain), .cfgBits(cfgBits),
    .cfgHalf(cfgHalf), .txData(txData), .txLoad(txLoad), .miso(miso),
    .rxData(rxData), .rxDone(rxDone), .sck(sck), .sckOe(sckOe), .mosi(mosi),
    .mosiOe(mosiOe), .ssel(ssel), .sselOe(sselOe)
  );

  // slave answer: pseudo-random, changes on falling edges
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign miso = lfsr[0];

  // ---------------- behavioural reference ----------------
  int         mBusy, mT, mCont, mPend, mDone, mPrevBit;
  logic [7:0] mFrame, mPendData, mRx, mRxOut;
  int         pn, ph, pe;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mT = 0; mCont = 0; mPend = 0; mDone = 0; mPrevBit = 0;
      mFrame = 0; mPendData = 0; mRx = 0; mRxOut = 0;
    end else begin
      pn = (cfgBits == 0) ? 8 : int'(cfgBits);
      ph = (cfgHalf == 0) ? 1 : int'(cfgHalf);
      mDone = 0;
      if (!cfgEnable) begin
        mBusy = 0; mCont = 0;
      end else if (mBusy == 0) begin
        if (mPend != 0) begin
          mBusy = 1; mT = 0; mFrame = mPendData; mPend = 0; mCont = 0; mRx = 0;
        end
      end else begin
        mT = mT + 1;
        pe = mT / ph;
        if ((mT % ph) == 0 && pe <= 2 * pn) begin
          if (((pe % 2) == 1) != (cfgPhase == 1'b1)) mRx = {mRx[6:0], miso};
          if (pe == 2 * pn) begin
            mRxOut = mRx;
            mDone  = 1;
            if (cfgMode == 2'b11 && mPend != 0) begin
              mPrevBit = int'(mFrame[0]);
              mFrame = mPendData; mPend = 0; mT = 0; mCont = 1; mRx = 0;
            end
          end
        end
        if (mT == ph * (2 * pn + 1)) begin mBusy = 0; mCont = 0; end
      end
      if (txLoad) begin mPend = 1; mPendData = txData; end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", tag, scen, $time, act, exp);
    end
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s [%s] t=%0t actual=%02h expected=%02h", tag, scen, $time, act, exp);
    end
  endtask

  // compare every clock, 1 ns after the rising edge
  int   cn, chh, ce, idx;
  logic eSck, eMosi, eSsel, act;
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      cn  = (cfgBits == 0) ? 8 : int'(cfgBits);
      chh = (cfgHalf == 0) ? 1 : int'(cfgHalf);
      act = (mBusy != 0);
      ce  = act ? ((mT / chh) > 2 * cn ? 2 * cn : mT / chh) : 0;
      eSck = logic'(ce % 2) ^ cfgPolarity;
      if (!act) eMosi = 1'b0;
      else if (!cfgPhase) begin
        idx = (ce / 2 > cn - 1) ? cn - 1 : ce / 2;
        eMosi = mFrame[cn - 1 - idx];
      end else if (ce == 0) eMosi = (mCont != 0) ? logic'(mPrevBit) : 1'b0;
      else begin
        idx = ((ce - 1) / 2 > cn - 1) ? cn - 1 : (ce - 1) / 2;
        eMosi = mFrame[cn - 1 - idx];
      end
      eSsel = ~(act ^ cfgSelInvert);
      chk((cfgMode == 2'b11) ? "R8 sck" : "R3 sck", sck, eSck);
      chk("R4 mosi", mosi, eMosi);
      chk((cfgMode == 2'b11) ? "R8 ssel" : "R7 ssel", ssel, eSsel);
      chk("R5 rxDone", rxDone, logic'(mDone != 0));
      chk8("R5 rxData", rxData, mRxOut);
      chk(cfgEnable ? "R9 sckOe" : "R2 sckOe", sckOe, cfgEnable & (~cfgOpenDrain | ~eSck));
      chk(cfgEnable ? "R9 mosiOe" : "R2 mosiOe", mosiOe, cfgEnable & (~cfgOpenDrain | ~eMosi));
      chk(cfgEnable ? "R6 sselOe" : "R2 sselOe", sselOe,
          cfgEnable & cfgSelOutput & (~cfgOpenDrain | ~eSsel));
    end
  end

  task automatic loadWord(input logic [7:0] d);
    @(negedge clk);
    txData = d; txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; cfgEnable = 1'b1; cfgMode = 2'b00; cfgPhase = 1'b0; cfgPolarity = 1'b0;
    cfgSelInvert = 1'b0; cfgSelOutput = 1'b1; cfgOpenDrain = 1'b0; cfgBits = 3'd0;
    cfgHalf = 4'd2; txData = 8'h00; txLoad = 1'b0;
    idle(3);
    // R1: reset state
    chk("R1 sck", sck, 1'b0);
    chk("R1 ssel", ssel, 1'b1);
    chk("R1 mosi", mosi, 1'b0);
    chk("R1 rxDone", rxDone, 1'b0);
    chk8("R1 rxData", rxData, 8'h00);
    rstN = 1'b1;
    idle(2);

    scen = "R4 R7 standard phase0 8 bits";
    loadWord(8'hA5);
    idle(60);

    scen = "R3 R4 R5 phase1 polarity1 5 bits";
    cfgPhase = 1'b1; cfgPolarity = 1'b1; cfgBits = 3'd5; cfgHalf = 4'd0;
    loadWord(8'h13);
    idle(30);

    scen = "R10 overwrite holding word";
    cfgPhase = 1'b0; cfgPolarity = 1'b0; cfgBits = 3'd0; cfgHalf = 4'd2;
    loadWord(8'h3C);
    idle(5);
    loadWord(8'h11);
    loadWord(8'hE7);
    idle(120);

    scen = "R8 framed back to back";
    cfgMode = 2'b11; cfgPhase = 1'b1; cfgBits = 3'd4; cfgHalf = 4'd3;
    loadWord(8'h09);
    idle(4);
    loadWord(8'h06);
    idle(34);
    loadWord(8'h0F);
    idle(150);

    scen = "R6 R7 R9 open drain inverted select mode01";
    cfgMode = 2'b01; cfgPhase = 1'b0; cfgPolarity = 1'b1; cfgBits = 3'd3; cfgHalf = 4'd4;
    cfgOpenDrain = 1'b1; cfgSelInvert = 1'b1;
    loadWord(8'h05);
    idle(80);
    cfgSelOutput = 1'b0;
    loadWord(8'h02);
    idle(60);

    scen = "R2 disable abort and resume";
    cfgMode = 2'b00; cfgPolarity = 1'b0; cfgBits = 3'd0; cfgOpenDrain = 1'b0;
    cfgSelInvert = 1'b0; cfgSelOutput = 1'b1;
    loadWord(8'hFF);
    idle(20);
    cfgEnable = 1'b0;
    idle(10);
    loadWord(8'h81);
    idle(10);
    cfgEnable = 1'b1;
    idle(100);

    finishRun();
  end

endmodule